// File: doc/BRIEF.md
# Log-to-float converter

This block turns a signed fixed-point base-2 logarithm back into an IEEE-754 single-precision word. The input carries a sign, three special-case flags and a two's-complement log value. The integer part of the log, floored, becomes the biased exponent. The fractional part `z` becomes the mantissa `2^z`. The block splits `z` into a high half and a low half. Each half indexes a small table of powers of two, and the two table outputs are multiplied. This replaces one table indexed by the whole fraction.

The converter is a two-stage pipeline. Stage one decodes the flags, biases the exponent and reads both tables. Stage two multiplies the table outputs, absorbs a possible carry into the exponent, saturates to infinity or flushes to zero, and registers the packed result. A new word may enter on every cycle. Denormal results are never produced, and the mantissa is truncated rather than rounded.

Top module: `lns_to_float`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly two clock cycles. While `rst` is high, `out_valid` and `out_float` are cleared to zero.
- R2: When `in_nan` is set, the output is `32'h7FC0_0000`. The other flags, the sign and the log value have no effect.
- R3: When `in_inf` is set and `in_nan` is clear, the output is `{in_sign, 8'hFF, 23'h0}`, whatever the log value.
- R4: When `in_zero` is set and neither `in_nan` nor `in_inf` is set, the output is `{in_sign, 31'h0}`, whatever the log value.
- R5: `in_log[20:12]` holds the signed integer part `k` of the log, and `in_log[11:0]` holds the unsigned fraction `z/4096`. For an ordinary word, the output exponent field is `k + 127` when that value lies in 1..254.
- R6: For an ordinary word, the mantissa field is `(2^z − 1)·2^23` truncated, within two units in the last place. When `z = 0`, the mantissa is exactly zero.
- R7: An ordinary word whose biased exponent reaches 255 or more gives `{in_sign, 8'hFF, 23'h0}`. An all-ones exponent field never comes with a nonzero mantissa, except in the NaN code.
- R8: An ordinary word whose biased exponent is 0 or less gives `{in_sign, 31'h0}`. No denormal output ever appears.
- R9: For an ordinary word, bit 31 of the output equals `in_sign`.
- R10: Words presented on consecutive cycles come out on consecutive cycles, in the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is present |
| in_sign | input | 1 | Sign of the value |
| in_zero | input | 1 | Value is zero |
| in_inf | input | 1 | Value is infinite |
| in_nan | input | 1 | Value is not a number |
| in_log | input | 21 | Two's-complement log2 of the magnitude: 9 integer bits, 12 fraction bits |
| out_valid | output | 1 | Output word is present |
| out_float | output | 32 | Single-precision result |

## Verification
Flag decoding and exponent-range saturation act on the same word in the same cycle. The bench provokes this by raising a special flag together with a log value that would overflow or underflow on its own. It also sets several flags at once. The checks confirm that the flag priority NaN > infinity > zero decides the result, and that the saturation path never leaks through. The bench also streams words on back-to-back cycles, so that one word's multiply runs in the same cycle as the next word's table read. The outputs must arrive in order, each one exact.

// File: rtl/lns2fp_pkg.sv
package lns2fp_pkg;
    // Log word layout: signed integer part above an unsigned fraction
    localparam int INT_W   = 9;
    localparam int HALF_W  = 6;
    localparam int FRAC_W  = 2 * HALF_W;
    localparam int LOG_W   = INT_W + FRAC_W;
    // Table entries are 1.TAB_FW fixed point
    localparam int TAB_FW  = 24;
    localparam int TAB_W   = TAB_FW + 1;
    localparam int PROD_W  = 2 * TAB_W;
    // Float fields
    localparam int MAN_W   = 23;
    localparam int FEXP_W  = 8;
    localparam int EXP_W   = INT_W + 2;
    localparam logic signed [EXP_W-1:0] EXP_BIAS = EXP_W'(127);
    localparam logic signed [EXP_W-1:0] EXP_ONE  = EXP_W'(1);
    localparam logic signed [EXP_W-1:0] EXP_TOP  = EXP_W'(255);
    localparam logic signed [EXP_W-1:0] EXP_NIL  = EXP_W'(0);
    localparam logic [31:0] QNAN_WORD = 32'h7FC0_0000;

    typedef enum logic [1:0] {
        KIND_NUM  = 2'd0,
        KIND_ZERO = 2'd1,
        KIND_INF  = 2'd2,
        KIND_NAN  = 2'd3
    } kind_e;

    typedef struct packed {
        kind_e                    kind;
        logic                     sign;
        logic signed [EXP_W-1:0]  bexp;
        logic [TAB_W-1:0]         hi_val;
        logic [TAB_W-1:0]         lo_val;
    } stage_t;

    // Flag priority: NaN over infinity over zero
    function automatic kind_e classify(input logic is_zero, input logic is_inf,
                                       input logic is_nan);
        if (is_nan)       return KIND_NAN;
        else if (is_inf)  return KIND_INF;
        else if (is_zero) return KIND_ZERO;
        else              return KIND_NUM;
    endfunction

    function automatic logic [31:0] inf_word(input logic s);
        return {s, {FEXP_W{1'b1}}, {MAN_W{1'b0}}};
    endfunction

    function automatic logic [31:0] zero_word(input logic s);
        return {s, {(FEXP_W + MAN_W){1'b0}}};
    endfunction
endpackage

// File: rtl/antilog_rom.sv
module antilog_rom
    import lns2fp_pkg::*;
#(
    parameter int AW         = HALF_W,
    parameter int SCALE_LOG2 = HALF_W
) (
    input  logic [AW-1:0]    idx,
    output logic [TAB_W-1:0] val
);
    localparam int DEPTH = 2 ** AW;

    logic [TAB_W-1:0] tbl [DEPTH];

    // Entry i holds 2^(i / 2^SCALE_LOG2) in 1.TAB_FW form, rounded
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        localparam real EXPO  = real'(i) / real'(2 ** SCALE_LOG2);
        localparam int  ENT_I = $rtoi($pow(2.0, EXPO) * real'(2 ** TAB_FW) + 0.5);
        assign tbl[i] = ENT_I[TAB_W-1:0];
    end

    assign val = tbl[idx];
endmodule

// File: rtl/mant_norm.sv
module mant_norm
    import lns2fp_pkg::*;
(
    input  logic [TAB_W-1:0]        hi_val,
    input  logic [TAB_W-1:0]        lo_val,
    input  logic signed [EXP_W-1:0] bexp_in,
    output logic [MAN_W-1:0]        mant,
    output logic signed [EXP_W-1:0] bexp_out
);
    logic [PROD_W-1:0] prod;
    logic              carry;
    logic              unused_low;

    // Product is in 2.(2*TAB_FW) form; a set top bit means it reached 2.0
    assign prod  = PROD_W'(hi_val) * PROD_W'(lo_val);
    assign carry = prod[PROD_W-1];

    assign mant     = carry ? prod[PROD_W-2 -: MAN_W] : prod[PROD_W-3 -: MAN_W];
    assign bexp_out = carry ? bexp_in + EXP_ONE : bexp_in;

    assign unused_low = ^prod[PROD_W-3-MAN_W:0];
endmodule

// File: rtl/lns_to_float.sv
module lns_to_float
    import lns2fp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_sign,
    input  logic             in_zero,
    input  logic             in_inf,
    input  logic             in_nan,
    input  logic [LOG_W-1:0] in_log,
    output logic             out_valid,
    output logic [31:0]      out_float
);
    logic signed [INT_W-1:0] int_part;
    logic [TAB_W-1:0]        hi_rd;
    logic [TAB_W-1:0]        lo_rd;
    stage_t                  s1_d;
    stage_t                  s1_q;
    logic                    s1_valid;

    assign int_part = in_log[LOG_W-1 -: INT_W];

    // Coarse factor: high half of the fraction, step 2^-HALF_W
    antilog_rom #(.AW(HALF_W), .SCALE_LOG2(HALF_W)) u_rom_hi (
        .idx (in_log[FRAC_W-1 -: HALF_W]),
        .val (hi_rd)
    );

    // Fine factor: low half of the fraction, step 2^-FRAC_W
    antilog_rom #(.AW(HALF_W), .SCALE_LOG2(FRAC_W)) u_rom_lo (
        .idx (in_log[HALF_W-1:0]),
        .val (lo_rd)
    );

    always_comb begin
        s1_d.kind   = classify(in_zero, in_inf, in_nan);
        s1_d.sign   = in_sign;
        s1_d.bexp   = EXP_W'(int_part) + EXP_BIAS;
        s1_d.hi_val = hi_rd;
        s1_d.lo_val = lo_rd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_q     <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_q     <= s1_d;
        end
    end

    logic [MAN_W-1:0]        mant;
    logic signed [EXP_W-1:0] fexp;
    logic [31:0]             packed_d;

    mant_norm u_norm (
        .hi_val   (s1_q.hi_val),
        .lo_val   (s1_q.lo_val),
        .bexp_in  (s1_q.bexp),
        .mant     (mant),
        .bexp_out (fexp)
    );

    always_comb begin
        unique case (s1_q.kind)
            KIND_NAN:  packed_d = QNAN_WORD;
            KIND_INF:  packed_d = inf_word(s1_q.sign);
            KIND_ZERO: packed_d = zero_word(s1_q.sign);
            default: begin
                if (fexp >= EXP_TOP)
                    packed_d = inf_word(s1_q.sign);
                else if (fexp <= EXP_NIL)
                    packed_d = zero_word(s1_q.sign);
                else
                    packed_d = {s1_q.sign, fexp[FEXP_W-1:0], mant};
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_float <= '0;
        end else begin
            out_valid <= s1_valid;
            out_float <= packed_d;
        end
    end
endmodule

// File: rtl/lns_to_float_chk.sv
module lns_to_float_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_sign,
    input logic        in_zero,
    input logic        in_inf,
    input logic        in_nan,
    input logic        out_valid,
    input logic [31:0] out_float
);
    // Cycles since reset, saturating, so that no $past reaches before reset
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    assert_nan_word_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_nan) |-> ##2 (out_valid && out_float == 32'h7FC0_0000));

    assert_inf_word_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_nan && in_inf) |-> ##2
        (out_valid && out_float == {$past(in_sign, 2), 8'hFF, 23'h0}));

    assert_zero_word_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_nan && !in_inf && in_zero) |-> ##2
        (out_valid && out_float == {$past(in_sign, 2), 31'h0}));

    assert_no_bad_allones_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_float[30:23] == 8'hFF && out_float != 32'h7FC0_0000)
        |-> (out_float[22:0] == 23'h0));

    assert_no_denormal_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_float[30:23] == 8'h00) |-> (out_float[22:0] == 23'h0));
endmodule

bind lns_to_float lns_to_float_chk u_chk (.*);

// File: tb/sim_lns_to_float.sv
module sim_lns_to_float;
    import lns2fp_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic             in_sign = 1'b0;
    logic             in_zero = 1'b0;
    logic             in_inf = 1'b0;
    logic             in_nan = 1'b0;
    logic [LOG_W-1:0] in_log = '0;
    logic             out_valid;
    logic [31:0]      out_float;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    lns_to_float u0 (.*);

    typedef struct packed {
        logic             nan;
        logic             inf;
        logic             zer;
        logic             sgn;
        logic [LOG_W-1:0] lg;
        logic [31:0]      res;
        logic [3:0]       req;
    } vec_t;

    // {nan, inf, zero, sign, log word, expected, requirement}
    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 1'b0, 1'b0, 21'h000000, 32'h3F80_0000, 4'd6},  // R6 1.0
        '{1'b0, 1'b0, 1'b0, 1'b0, 21'h003000, 32'h4100_0000, 4'd5},  // R5 8.0
        '{1'b0, 1'b0, 1'b0, 1'b1, 21'h1FF000, 32'hBF00_0000, 4'd9},  // R9 -0.5
        '{1'b0, 1'b0, 1'b0, 1'b0, 21'h07F000, 32'h7F00_0000, 4'd5},  // R5 top exponent
        '{1'b0, 1'b0, 1'b0, 1'b0, 21'h080000, 32'h7F80_0000, 4'd7},  // R7 overflow
        '{1'b0, 1'b0, 1'b0, 1'b1, 21'h080000, 32'hFF80_0000, 4'd7},  // R7 negative overflow
        '{1'b0, 1'b0, 1'b0, 1'b0, 21'h0FF000, 32'h7F80_0000, 4'd7},  // R7 far overflow
        '{1'b0, 1'b0, 1'b0, 1'b0, 21'h182000, 32'h0080_0000, 4'd5},  // R5 bottom exponent
        '{1'b0, 1'b0, 1'b0, 1'b0, 21'h181000, 32'h0000_0000, 4'd8},  // R8 underflow
        '{1'b0, 1'b0, 1'b0, 1'b1, 21'h181800, 32'h8000_0000, 4'd8},  // R8 floor keeps -127
        '{1'b0, 1'b0, 1'b0, 1'b0, 21'h100000, 32'h0000_0000, 4'd8},  // R8 most negative log
        '{1'b1, 1'b0, 1'b0, 1'b1, 21'h000000, 32'h7FC0_0000, 4'd2},  // R2 nan
        '{1'b1, 1'b1, 1'b1, 1'b1, 21'h080000, 32'h7FC0_0000, 4'd2},  // R2 all flags
        '{1'b0, 1'b1, 1'b0, 1'b1, 21'h003000, 32'hFF80_0000, 4'd3},  // R3 inf
        '{1'b0, 1'b1, 1'b1, 1'b0, 21'h181000, 32'h7F80_0000, 4'd3},  // R3 inf over zero, underflowing log
        '{1'b0, 1'b0, 1'b1, 1'b1, 21'h003000, 32'h8000_0000, 4'd4},  // R4 zero
        '{1'b0, 1'b0, 1'b1, 1'b0, 21'h080000, 32'h0000_0000, 4'd4}   // R4 zero over overflowing log
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    // Drives one word at a falling edge and holds it for one cycle
    task automatic send(input logic n, input logic i, input logic z, input logic s,
                        input logic [LOG_W-1:0] lg);
        in_valid = 1'b1; in_nan = n; in_inf = i; in_zero = z; in_sign = s; in_log = lg;
        @(negedge clk);
        in_valid = 1'b0; in_nan = 1'b0; in_inf = 1'b0; in_zero = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog actual=hang expected=finish");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset out_valid", {31'h0, out_valid}, 32'h0);
        check("R1 reset out_float", out_float, 32'h0);
        rst = 1'b0;
        @(negedge clk);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            send(VEC[v].nan, VEC[v].inf, VEC[v].zer, VEC[v].sgn, VEC[v].lg);
            if (v == 0) check("R1 no output after one cycle", {31'h0, out_valid}, 32'h0);
            @(negedge clk);
            check($sformatf("R1 valid vec %0d", v), {31'h0, out_valid}, 32'h1);
            check($sformatf("R%0d vec %0d", VEC[v].req, v), out_float, VEC[v].res);
        end

        // R6: nonzero fractions, checked against 2^z within two ulps
        for (int t = 0; t < 10; t++) begin
            int          fr;
            int          k;
            int          m_exp;
            int          m_act;
            logic [8:0]  top_exp;
            fr = (t % 5 == 0) ? 1 : (t % 5 == 1) ? 2048 : (t % 5 == 2) ? 4095 :
                 (t % 5 == 3) ? 291 : 2748;
            k  = (t < 5) ? 0 : -1;
            send(1'b0, 1'b0, 1'b0, t[0], {9'(k), 12'(fr)});
            @(negedge clk);
            m_exp   = $rtoi(($pow(2.0, real'(fr) / 4096.0) - 1.0) * 8388608.0);
            m_act   = int'(out_float[22:0]);
            top_exp = {t[0], 8'(k + 127)};
            check($sformatf("R5 exponent frac %0d", fr), {23'h0, out_float[31:23]}, {23'h0, top_exp});
            n_chk++;
            if (m_act - m_exp > 2 || m_exp - m_act > 2) begin
                n_fail++;
                $display("FAIL R6 mantissa frac %0d actual=%h expected=%h", fr, m_act, m_exp);
            end
        end

        // R10: three words back to back
        in_valid = 1'b1; in_sign = 1'b0; in_log = 21'h001000;
        @(negedge clk);
        in_log = 21'h002000;
        @(negedge clk);
        check("R10 stream first", out_float, 32'h4000_0000);
        in_sign = 1'b1; in_log = 21'h1FE000;
        @(negedge clk);
        check("R10 stream second", out_float, 32'h4080_0000);
        in_valid = 1'b0;
        @(negedge clk);
        check("R10 stream third", out_float, 32'hBE80_0000);
        @(negedge clk);
        check("R1 valid drops after stream", {31'h0, out_valid}, 32'h0);

        // R1: reset while a word is in flight
        send(1'b0, 1'b0, 1'b0, 1'b0, 21'h003000);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset flushes valid", {31'h0, out_valid}, 32'h0);
        check("R1 reset flushes data", out_float, 32'h0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 idle after reset", {31'h0, out_valid}, 32'h0);

        summary();
        $finish;
    end
endmodule